// File: doc/BRIEF.md
# Word-Shift UART Transmitter

This block produces asynchronous serial frames from a byte stream using nothing more than a word shifter. Each character is turned into a complete line word at the moment it is accepted. A left shift puts a zero start bit at bit 0, a mask keeps only the selected number of data bits, and stop ones are ORed in above them. The word is then clocked out least significant bit first, exactly as a plain synchronous word would be.

Characters arrive on a valid/ready port and wait in an eight-entry holding queue. The line idles high in two ways. Just after reset or after a format change, two all-ones words are shifted. When transmission is switched off, one more all-ones word is shifted before the transmitter actually stops. The character format and the bit-rate divider can be changed only while the transmitter is off.

Top module: `wordshift_uart_tx`

## Requirements
- R1: After reset, ser_out, in_ready and hold_empty are 1; fifo_full, overflow and tx_on are 0. The format is 8 data bits with one stop bit, and the divider is RESET_DIV.
- R2: Each character is sent as a 0 start bit followed by its data bits, LSB first. cfg_size selects the data width: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Character bits above that width are not sent.
- R3: After the data come one stop bit at 1, or two when cfg_two_stop is 1. The word is therefore size+2 or size+3 bits long.
- R4: Each bit lasts 2*(div+1) clock cycles. Start bits of back-to-back characters are one word length plus one cycle apart.
- R5: The holding queue accepts 8 characters while transmission is off. When it has 8, fifo_full is 1 and in_ready is 0.
- R6: A character offered while fifo_full is 1 is discarded and never sent. It sets overflow, which stays at 1 until reset.
- R7: While tx_on is 0, ser_out stays 1, even when characters are queued.
- R8: After reset or an accepted format write, enabling sends two all-ones words before the first character. The first start bit therefore comes at least 2*L*(2*(div+1)) cycles after tx_en rises, where L is the word length.
- R9: When tx_en falls, the current word finishes and one all-ones word is shifted. tx_on then drops, about one word time later. Queued characters stay queued.
- R10: A format write while tx_on is 1 is ignored. Later characters keep the old width, stop count and bit time.
- R11: hold_empty is 1 exactly when no character waits in the holding queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Format write strobe, accepted only while tx_on is 0 |
| cfg_size | input | 2 | Data width select: 00=5, 01=6, 10=7, 11=8 |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_div | input | DIV_W | Bit-rate divider; bit time is 2*(div+1) cycles |
| tx_en | input | 1 | Transmit enable |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character value |
| in_ready | output | 1 | Queue can take a character |
| ser_out | output | 1 | Serial line, idle high |
| tx_on | output | 1 | Transmitter running or draining |
| fifo_full | output | 1 | Holding queue full |
| hold_empty | output | 1 | Holding queue empty |
| overflow | output | 1 | Sticky: a character was dropped |

## Verification
Four formats are exercised, with each data width and both stop counts paired with different dividers. The patterns are chosen so that a wrong data mask, a wrong stop count or a wrong bit time each shows up as a decode or spacing error. Characters carrying bits above the selected width check the masking. All-zero and all-one characters separate start and stop errors from data errors. The delay from enable to the first start bit tells a primed start from an unprimed one. A format write made while running shows whether the lock holds. A ninth character offered to a full queue must disappear from the output stream and leave the overflow flag set.

// File: rtl/wsu_pkg.sv
package wsu_pkg;
    localparam int CHAR_MAX = 8;
    localparam int FRAME_W  = CHAR_MAX + 3;
    localparam int LEN_W    = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {CS5 = 2'b00, CS6 = 2'b01, CS7 = 2'b10, CS8 = 2'b11} char_size_e;

    typedef struct packed {
        char_size_e size;
        logic       two_stop;
    } fmt_t;

    typedef struct packed {
        logic [LEN_W-1:0]   len;
        logic [FRAME_W-1:0] bits;
    } tx_word_t;

    typedef enum logic [1:0] {TX_OFF, TX_RUN, TX_DRAIN} tx_state_e;

    function automatic int unsigned char_bits(char_size_e s);
        return 5 + int'(s);
    endfunction

    function automatic logic [LEN_W-1:0] word_len(fmt_t f);
        return LEN_W'(char_bits(f.size) + 2 + (f.two_stop ? 1 : 0));
    endfunction

    // shift left, keep the data field, OR in stop ones
    function automatic logic [FRAME_W-1:0] frame_word(logic [CHAR_MAX-1:0] ch, fmt_t f);
        logic [FRAME_W-1:0] dmask;
        logic [FRAME_W-1:0] smask;
        int unsigned        n;
        n     = char_bits(f.size);
        dmask = ((FRAME_W'(1) << n) - FRAME_W'(1)) << 1;
        smask = FRAME_W'(1) << (n + 1);
        if (f.two_stop) smask = smask | (FRAME_W'(1) << (n + 2));
        return ((FRAME_W'(ch) << 1) & dmask) | smask;
    endfunction
endpackage

// File: rtl/wsu_fifo.sv
module wsu_fifo
    import wsu_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  tx_word_t din,
    input  logic     pop,
    output tx_word_t dout,
    output logic     empty,
    output logic     full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tx_word_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;

    function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= next_ptr(wr_ptr);
            if (pop)  rd_ptr <= next_ptr(rd_ptr);
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    assert_full_holds_R5: assert property (@(posedge clk) disable iff (rst)
        full && !pop |=> full);
    assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/wsu_shifter.sv
module wsu_shifter
    import wsu_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  tx_word_t           word,
    input  logic [DIV_W-1:0]   div,
    output logic               busy,
    output logic               ser_out
);
    logic [FRAME_W-1:0] sh_word;
    logic [LEN_W-1:0]   left;
    logic [DIV_W:0]     baud_cnt;
    logic [DIV_W:0]     limit;

    assign limit = {div, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            sh_word  <= '1;
            left     <= '0;
            baud_cnt <= '0;
        end else if (!busy) begin
            if (load) begin
                sh_word  <= word.bits;
                left     <= word.len;
                baud_cnt <= '0;
                busy     <= 1'b1;
            end
        end else if (baud_cnt == limit) begin
            baud_cnt <= '0;
            sh_word  <= {1'b1, sh_word[FRAME_W-1:1]};
            if (left == LEN_W'(1)) busy <= 1'b0;
            else                   left <= left - LEN_W'(1);
        end else begin
            baud_cnt <= baud_cnt + 1'b1;
        end
    end

    assign ser_out = busy ? sh_word[0] : 1'b1;

    assert_bit_hold_R4: assert property (@(posedge clk) disable iff (rst)
        busy && (baud_cnt != limit) |=> $stable(sh_word));
endmodule

// File: rtl/wordshift_uart_tx.sv
module wordshift_uart_tx
    import wsu_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 12,
    parameter int RESET_DIV  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_size,
    input  logic             cfg_two_stop,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             tx_en,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             ser_out,
    output logic             tx_on,
    output logic             fifo_full,
    output logic             hold_empty,
    output logic             overflow
);
    localparam logic [1:0] PRIME_WORDS = 2'd2;

    fmt_t             fmt_q;
    logic [DIV_W-1:0] div_q;
    tx_state_e        st, st_n;
    logic [1:0]       prime_q, prime_n;
    logic             ovf_q;

    logic             push, pop, load, sh_busy, q_empty, q_full, cfg_ok;
    tx_word_t         q_in, q_out, load_word, filler;

    assign cfg_ok = cfg_we && (st == TX_OFF);
    assign push   = in_valid && !q_full;
    assign q_in   = '{len: word_len(fmt_q), bits: frame_word(in_data, fmt_q)};
    assign filler = '{len: word_len(fmt_q), bits: '1};

    always_comb begin
        st_n      = st;
        prime_n   = prime_q;
        load      = 1'b0;
        pop       = 1'b0;
        load_word = filler;
        case (st)
            TX_OFF: begin
                if (cfg_ok)     prime_n = PRIME_WORDS;
                if (tx_en)      st_n = TX_RUN;
            end
            TX_RUN: begin
                if (!sh_busy) begin
                    if (!tx_en) begin
                        load = 1'b1;
                        st_n = TX_DRAIN;
                    end else if (prime_q != 2'd0) begin
                        load    = 1'b1;
                        prime_n = prime_q - 2'd1;
                    end else if (!q_empty) begin
                        load      = 1'b1;
                        pop       = 1'b1;
                        load_word = q_out;
                    end
                end
            end
            TX_DRAIN: begin
                if (!sh_busy) st_n = TX_OFF;
            end
            default: st_n = TX_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= TX_OFF;
            prime_q <= PRIME_WORDS;
            fmt_q   <= '{size: CS8, two_stop: 1'b0};
            div_q   <= DIV_W'(RESET_DIV);
            ovf_q   <= 1'b0;
        end else begin
            st      <= st_n;
            prime_q <= prime_n;
            if (cfg_ok) begin
                fmt_q <= '{size: char_size_e'(cfg_size), two_stop: cfg_two_stop};
                div_q <= cfg_div;
            end
            if (in_valid && q_full) ovf_q <= 1'b1;
        end
    end

    wsu_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (q_in),
        .pop   (pop),
        .dout  (q_out),
        .empty (q_empty),
        .full  (q_full)
    );

    wsu_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .word    (load_word),
        .div     (div_q),
        .busy    (sh_busy),
        .ser_out (ser_out)
    );

    assign in_ready   = !q_full;
    assign fifo_full  = q_full;
    assign hold_empty = q_empty;
    assign overflow   = ovf_q;
    assign tx_on      = (st != TX_OFF);

    assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (st != TX_OFF) |=> ($stable(fmt_q) && $stable(div_q)));
    assert_off_line_high_R7: assert property (@(posedge clk) disable iff (rst)
        (st == TX_OFF) |-> (ser_out && !sh_busy));
    assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    assert_drop_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && q_full) |=> ovf_q);
endmodule

// File: tb/wordshift_uart_tx_test.sv
module wordshift_uart_tx_test;
    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_size = 2'b11;
    logic             cfg_two_stop = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             tx_en = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic             in_ready, ser_out, tx_on, fifo_full, hold_empty, overflow;

    int     errors = 0;
    int     checks = 0;
    int     cur_cs = 8;
    int     cur_two = 0;
    int     cur_div = 3;
    int     exp_q[$];
    longint falls[$];
    longint cyc = 0;
    bit     done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wordshift_uart_tx #(.FIFO_DEPTH(8), .DIV_W(DIV_W), .RESET_DIV(3)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_size(cfg_size),
        .cfg_two_stop(cfg_two_stop), .cfg_div(cfg_div), .tx_en(tx_en),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .ser_out(ser_out), .tx_on(tx_on), .fifo_full(fifo_full),
        .hold_empty(hold_empty), .overflow(overflow)
    );

    function automatic int bit_p();
        return 2 * (cur_div + 1);
    endfunction
    function automatic int word_l();
        return cur_cs + 2 + cur_two;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: decode frames at bit centres and compare with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && ser_out === 1'b0) begin
                int  p;
                int  val;
                bit  start_ok;
                bit  stop_ok;
                falls.push_back(cyc);
                p = bit_p();
                repeat (p / 2) @(negedge clk);
                start_ok = (ser_out === 1'b0);
                val = 0;
                for (int k = 0; k < cur_cs; k++) begin
                    repeat (p) @(negedge clk);
                    if (ser_out === 1'b1) val = val | (1 << k);
                end
                stop_ok = 1'b1;
                for (int s = 0; s < 1 + cur_two; s++) begin
                    repeat (p) @(negedge clk);
                    if (ser_out !== 1'b1) stop_ok = 1'b0;
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected frame", val, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(start_ok && (val == e), "R2 frame data", val, e);
                    chk(stop_ok, "R3 stop bits", stop_ok, 1);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic push(input int ch);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'(ch);
        exp_q.push_back(ch & ((1 << cur_cs) - 1));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic write_cfg(input int sel, input int two, input int div, input bit expect_ok);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_size = 2'(sel);
        cfg_two_stop = two[0];
        cfg_div = DIV_W'(div);
        @(negedge clk);
        cfg_we = 1'b0;
        if (expect_ok) begin
            cur_cs = 5 + sel;
            cur_two = two;
            cur_div = div;
        end
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2 * bit_p()) @(negedge clk);
    endtask

    task automatic start_burst(output longint en_c);
        @(negedge clk);
        falls.delete();
        en_c = cyc;
        tx_en = 1'b1;
    endtask

    task automatic check_prime_and_gap(input longint en_c, input string tag);
        longint lp;
        lp = longint'(word_l()) * bit_p();
        if (falls.size() >= 2) begin
            longint d0, d1;
            d0 = falls[0] - en_c;
            d1 = falls[1] - falls[0];
            chk(d0 >= 2 * lp + 2 && d0 <= 2 * lp + 6, {"R8 prime delay ", tag}, d0, 2 * lp + 4);
            chk(d1 >= lp && d1 <= lp + 2, {"R4 frame spacing ", tag}, d1, lp + 1);
        end else begin
            chk(1'b0, {"R4 frames seen ", tag}, falls.size(), 2);
        end
    endtask

    task automatic stop_tx();
        longint lp;
        lp = longint'(word_l()) * bit_p();
        repeat (2 * bit_p()) @(negedge clk);
        tx_en = 1'b0;
        repeat (int'(lp) - 1) @(negedge clk);
        chk(tx_on == 1'b1, "R9 still draining", tx_on, 1);
        chk(ser_out == 1'b1, "R9 filler line high", ser_out, 1);
        repeat (6) @(negedge clk);
        chk(tx_on == 1'b0, "R9 stopped after filler", tx_on, 0);
    endtask

    initial begin
        longint en_c;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ser_out == 1'b1, "R1 ser_out", ser_out, 1);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
        chk(fifo_full == 1'b0, "R1 fifo_full", fifo_full, 0);
        chk(overflow == 1'b0, "R1 overflow", overflow, 0);
        chk(tx_on == 1'b0, "R1 tx_on", tx_on, 0);

        // default format, queued while off
        push(8'h5A); push(8'hC3); push(8'h81);
        chk(hold_empty == 1'b0, "R11 queue holds data", hold_empty, 0);
        repeat (40) @(negedge clk);
        chk(ser_out == 1'b1, "R7 line high while off", ser_out, 1);
        chk(exp_q.size() == 3, "R7 nothing sent while off", exp_q.size(), 3);
        start_burst(en_c);
        push(8'h00); push(8'hFF);
        wait_empty();
        check_prime_and_gap(en_c, "8N1");
        chk(hold_empty == 1'b1, "R11 queue drained", hold_empty, 1);
        stop_tx();

        // 5 data bits, two stops, fast divider; upper bits dropped
        write_cfg(0, 1, 1, 1'b1);
        push(8'hA5); push(8'h3E); push(8'h11);
        start_burst(en_c);
        wait_empty();
        check_prime_and_gap(en_c, "5-2");
        // R10: format write while running is ignored
        write_cfg(3, 0, 5, 1'b0);
        push(8'hF7); push(8'h0A);
        wait_empty();
        stop_tx();

        // 6 bits one stop, then 7 bits two stops
        for (int v = 0; v < 2; v++) begin
            if (v == 0) write_cfg(1, 0, 2, 1'b1);
            else        write_cfg(2, 1, 0, 1'b1);
            push(8'hEA); push(8'h55); push(8'h7F);
            start_burst(en_c);
            wait_empty();
            check_prime_and_gap(en_c, (v == 0) ? "6-1" : "7-2");
            stop_tx();
        end

        // R5 / R6: fill the queue, then overfill
        write_cfg(3, 0, 1, 1'b1);
        for (int i = 0; i < 8; i++) push(8'h10 + i * 8'h13);
        chk(fifo_full == 1'b1, "R5 full after 8", fifo_full, 1);
        chk(in_ready == 1'b0, "R5 not ready when full", in_ready, 0);
        chk(overflow == 1'b0, "R6 no overflow yet", overflow, 0);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = 8'h99;
        @(negedge clk);
        in_valid = 1'b0;
        chk(overflow == 1'b1, "R6 overflow set", overflow, 1);
        start_burst(en_c);
        wait_empty();
        repeat (4 * word_l() * bit_p()) @(negedge clk);
        chk(falls.size() == 8, "R6 dropped char not sent", falls.size(), 8);
        chk(overflow == 1'b1, "R6 overflow sticky", overflow, 1);
        chk(hold_empty == 1'b1, "R11 empty after burst", hold_empty, 1);
        stop_tx();

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule